// File: doc/BRIEF.md
# Descriptor Engine Control Unit

This block holds the control register of a scatter-gather DMA descriptor engine and sequences that engine. Software writes one 32-bit control word. The unit then starts descriptors on an abstract datapath for as long as its run flag stays set. For each descriptor it waits for the transfer-done report. It then asks for the descriptor writeback and tells the writeback whether to clear the hardware-ownership flag. The request is held until the writeback is acknowledged.

Completed writebacks are counted. When the programmed count is reached, a single interrupt line is raised. A two-write software reset clears the whole unit and pulses a reset strobe to the datapath for a fixed number of cycles. The engine halts on its own in three cases: software drops the run flag, the next descriptor is not owned by hardware, or a streaming error is seen while stop-on-error is set.

Top module: `desc_ctrl_unit`

## Requirements
- R1: With the run flag (bit 5) at 1 and `dp_owned` high, the unit emits one single-cycle `dp_start` per descriptor and starts the next descriptor after each writeback, with no software action.
- R2: Clearing the run flag while a descriptor is in flight lets that descriptor finish, including its writeback. No further `dp_start` follows.
- R3: When the parameter STREAM_TO_MEM is 1 and the stop-on-error flag (bit 6) is 1, a `dp_err` seen during a transfer makes the unit drop the run flag once that descriptor's writeback completes. With bit 6 at 0, errors do not stop the engine.
- R4: With the count-interrupt enable (bit 7) at 1, `irq` rises after the writeback whose completion brings the completed-descriptor count to the limit in bits 15:8. The count then restarts from zero.
- R5: A limit of zero never raises the count interrupt.
- R6: While `wb_req` is high, `wb_clr_own` equals the inverse of the park flag (bit 17). The request stays high until `wb_ack`.
- R7: A write with bit 31 at 1 clears a pending interrupt.
- R8: `irq` only rises in the cycle after a `wb_ack` that completed a descriptor writeback.
- R9: Two consecutive writes with bit 16 at 1 trigger a software reset. A write with bit 16 at 0 in between disarms it. The reset zeroes every field, the counter and the pending interrupt. It holds `dp_reset` high for SRST_CYCLES cycles, and register writes are ignored during that time.
- R10: The run, stop-on-error, enable, limit and park fields read back as written. Bits 4:0, 16 and 30:18 (writes to them are ignored) and bit 31 read as 0.
- R11: If the run flag is set but `dp_owned` is low when the next descriptor would start, the unit clears the run flag and stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data |
| dp_owned | input | 1 | Ownership flag of the next descriptor presented |
| dp_start | output | 1 | Start pulse for one descriptor |
| dp_done | input | 1 | Transfer of the current descriptor finished |
| dp_err | input | 1 | Streaming error during the current transfer |
| wb_req | output | 1 | Descriptor writeback request |
| wb_clr_own | output | 1 | Writeback should clear the ownership flag |
| wb_ack | input | 1 | Writeback completed |
| dp_reset | output | 1 | Software reset strobe to the datapath |
| irq | output | 1 | Count interrupt |

## Verification
On every cycle, the embedded assertions check the following: start pulses last one cycle; a transfer in flight always moves on to writeback rather than back to idle; the writeback request is held until acknowledged; the interrupt rises only right after a writeback completion and never with a zero limit; the reset strobe starts only on an armed second write. The scenarios have to show the things that depend on software sequencing. These are the field readback, the exact descriptor on which the interrupt fires, and the counter restarting after it fires. They also cover the halts on a stop request, a non-owned descriptor or an error, the disarming of the reset, and the writes dropped during the reset.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  localparam int RUN_B     = 5;
  localparam int ESTOP_B   = 6;
  localparam int CIE_B     = 7;
  localparam int LIM_LO    = 8;
  localparam int LIM_W     = 8;
  localparam int SRST_B    = 16;
  localparam int PARK_B    = 17;
  localparam int ICLR_B    = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic             park;
    logic [LIM_W-1:0] lim;
    logic             cnt_ie;
    logic             err_stop;
    logic             run;
  } ctrl_fields_t;
endpackage

// File: rtl/dcu_srst.sv
module dcu_srst #(
  parameter int SRST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic arm_bit_i,
  output logic fire_o,
  output logic active_o
);
  localparam int CW = $clog2(SRST_CYCLES + 1);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign active_o = (cnt_q != '0);
  assign fire_o   = !active_o && wr_i && arm_bit_i && armed_q;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (active_o) begin
      armed_d = 1'b0;
      cnt_d   = cnt_q - 1'b1;
    end else if (fire_o) begin
      armed_d = 1'b0;
      cnt_d   = CW'(SRST_CYCLES);
    end else if (wr_i) begin
      armed_d = arm_bit_i;
    end
  end

  assign en = active_o | wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R9
  srst_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(wr_i && arm_bit_i && armed_q));
endmodule

// File: rtl/dcu_regs.sv
module dcu_regs
  import dcu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [31:0]  wdata_i,
  input  logic         clear_i,
  input  logic         run_clr_i,
  output ctrl_fields_t fields_o,
  output logic [31:0]  rdata_o,
  output logic         irq_clr_o
);
  ctrl_fields_t f_q, f_d;
  logic         f_en;
  logic         rsvd_unused;

  assign rsvd_unused = ^{wdata_i[4:0], wdata_i[30:18], wdata_i[SRST_B]};

  always_comb begin
    f_d = f_q;
    if (clear_i) begin
      f_d = '0;
    end else if (wr_en_i) begin
      f_d.run      = wdata_i[RUN_B];
      f_d.err_stop = wdata_i[ESTOP_B];
      f_d.cnt_ie   = wdata_i[CIE_B];
      f_d.lim      = wdata_i[LIM_LO +: LIM_W];
      f_d.park     = wdata_i[PARK_B];
    end else if (run_clr_i) begin
      f_d.run = 1'b0;
    end
  end

  assign f_en = clear_i | wr_en_i | run_clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    f_q <= '0;
    else if (f_en) f_q <= f_d;
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[RUN_B]            = f_q.run;
    rdata_o[ESTOP_B]          = f_q.err_stop;
    rdata_o[CIE_B]            = f_q.cnt_ie;
    rdata_o[LIM_LO +: LIM_W]  = f_q.lim;
    rdata_o[PARK_B]           = f_q.park;
  end

  assign fields_o  = f_q;
  assign irq_clr_o = wr_en_i & wdata_i[ICLR_B];
endmodule

// File: rtl/dcu_seq.sv
module dcu_seq
  import dcu_pkg::*;
#(
  parameter bit STREAM_TO_MEM = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic err_stop_i,
  input  logic owned_i,
  input  logic done_i,
  input  logic err_i,
  input  logic wb_ack_i,
  output logic start_o,
  output logic wb_req_o,
  output logic desc_done_o,
  output logic run_clr_o
);
  seq_state_e state_q, state_d;
  logic       err_q, err_d;
  logic       err_hit;
  logic       en;

  generate
    if (STREAM_TO_MEM) begin : g_err_stop
      assign err_hit = err_stop_i & err_i;
    end else begin : g_no_err_stop
      logic err_unused;
      assign err_unused = err_stop_i ^ err_i;
      assign err_hit    = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d     = state_q;
    err_d       = err_q;
    start_o     = 1'b0;
    wb_req_o    = 1'b0;
    desc_done_o = 1'b0;
    run_clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (run_i) begin
          if (owned_i) begin
            start_o = 1'b1;
            err_d   = 1'b0;
            state_d = ST_XFER;
          end else begin
            run_clr_o = 1'b1;
          end
        end
      end
      ST_XFER: begin
        if (err_hit) err_d   = 1'b1;
        if (done_i)  state_d = ST_WB;
      end
      ST_WB: begin
        wb_req_o = 1'b1;
        if (wb_ack_i) begin
          desc_done_o = 1'b1;
          run_clr_o   = err_q;
          err_d       = 1'b0;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (clear_i) begin
      state_d     = ST_IDLE;
      err_d       = 1'b0;
      start_o     = 1'b0;
      wb_req_o    = 1'b0;
      desc_done_o = 1'b0;
      run_clr_o   = 1'b0;
    end
  end

  assign en = clear_i | run_i | (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else if (en) begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R2
  xfer_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && !clear_i) |=> (state_q == ST_XFER || state_q == ST_WB));

  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !wb_ack_i && !clear_i) |=> (state_q == ST_WB));
endmodule

// File: rtl/dcu_irq.sv
module dcu_irq #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             cnt_ie_i,
  input  logic [LIM_W-1:0] lim_i,
  input  logic             desc_done_i,
  input  logic             irq_clr_i,
  output logic             irq_o
);
  logic [LIM_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             pend_q, pend_d;
  logic             hit;
  logic             en;

  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = desc_done_i && (lim_i != '0) && (cnt_inc >= lim_i);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (clear_i) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      if (desc_done_i) cnt_d = hit ? '0 : cnt_inc;
      if (hit && cnt_ie_i) pend_d = 1'b1;
      else if (irq_clr_i)  pend_d = 1'b0;
    end
  end

  assign en = clear_i | desc_done_i | irq_clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign irq_o = pend_q;

  // R8
  irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(desc_done_i));

  // R5
  zero_lim_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_i == '0) |=> !$rose(pend_q));
endmodule

// File: rtl/desc_ctrl_unit.sv
module desc_ctrl_unit
  import dcu_pkg::*;
#(
  parameter int SRST_CYCLES   = 4,
  parameter bit STREAM_TO_MEM = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        dp_owned,
  output logic        dp_start,
  input  logic        dp_done,
  input  logic        dp_err,
  output logic        wb_req,
  output logic        wb_clr_own,
  input  logic        wb_ack,
  output logic        dp_reset,
  output logic        irq
);
  ctrl_fields_t fields;
  logic         srst_fire, srst_active, clear;
  logic         wr_en, run_clr, desc_done, irq_clr;

  assign clear = srst_fire | srst_active;
  assign wr_en = reg_wr & ~srst_active;

  dcu_srst #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_en),
    .arm_bit_i (reg_wdata[SRST_B]),
    .fire_o    (srst_fire),
    .active_o  (srst_active)
  );

  dcu_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wdata_i   (reg_wdata),
    .clear_i   (clear),
    .run_clr_i (run_clr),
    .fields_o  (fields),
    .rdata_o   (reg_rdata),
    .irq_clr_o (irq_clr)
  );

  dcu_seq #(.STREAM_TO_MEM(STREAM_TO_MEM)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .run_i       (fields.run),
    .err_stop_i  (fields.err_stop),
    .owned_i     (dp_owned),
    .done_i      (dp_done),
    .err_i       (dp_err),
    .wb_ack_i    (wb_ack),
    .start_o     (dp_start),
    .wb_req_o    (wb_req),
    .desc_done_o (desc_done),
    .run_clr_o   (run_clr)
  );

  dcu_irq #(.LIM_W(LIM_W)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .cnt_ie_i    (fields.cnt_ie),
    .lim_i       (fields.lim),
    .desc_done_i (desc_done),
    .irq_clr_i   (irq_clr),
    .irq_o       (irq)
  );

  assign wb_clr_own = wb_req & ~fields.park;
  assign dp_reset   = srst_active;
endmodule

// File: tb/desc_ctrl_unit_tb.sv
module desc_ctrl_unit_tb;
  localparam int SRST_CYCLES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dp_owned = 1'b0;
  logic        dp_start;
  logic        dp_done = 1'b0;
  logic        dp_err = 1'b0;
  logic        wb_req;
  logic        wb_clr_own;
  logic        wb_ack = 1'b0;
  logic        dp_reset;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  desc_ctrl_unit #(.SRST_CYCLES(SRST_CYCLES), .STREAM_TO_MEM(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dp_owned(dp_owned), .dp_start(dp_start),
    .dp_done(dp_done), .dp_err(dp_err), .wb_req(wb_req),
    .wb_clr_own(wb_clr_own), .wb_ack(wb_ack), .dp_reset(dp_reset), .irq(irq)
  );

  // write data, expected readback (run bit kept 0 in the table)
  localparam logic [63:0] VECS [6] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'hFFFE_FFDF, 32'h0002_FFC0},
    {32'h0001_0040, 32'h0000_0040},
    {32'h0000_AB80, 32'h0000_AB80},
    {32'h8002_0000, 32'h0002_0000},
    {32'h7FFC_001F, 32'h0000_0000}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wait_start(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (dp_start) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    if (seen) @(negedge clk);
  endtask

  task automatic finish_desc(input logic err, input logic exp_clr, input logic nxt_owned,
                             input string req, output logic irq_pre);
    dp_done = 1'b1; dp_err = err;
    @(negedge clk);
    dp_done = 1'b0; dp_err = 1'b0;
    chk({31'b0, wb_req}, 32'd1, req, "writeback requested");
    chk({31'b0, wb_clr_own}, {31'b0, exp_clr}, "R6", "ownership clear select");
    @(negedge clk);
    chk({31'b0, wb_req}, 32'd1, "R6", "request held until ack");
    irq_pre = irq;
    wb_ack = 1'b1; dp_owned = nxt_owned;
    @(negedge clk);
    wb_ack = 1'b0;
  endtask

  task automatic no_start(input int n, input string req);
    logic any;
    any = 1'b0;
    for (int i = 0; i < n; i++) begin
      any |= dp_start;
      @(negedge clk);
    end
    chk({31'b0, any}, 32'd0, req, "no start after halt");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic seen, ipre;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata, 32'h0, "R10", "reset readback");
    chk({28'b0, irq, dp_start, wb_req, dp_reset}, 32'h0, "R9", "reset outputs");

    // R10 readback table
    for (int i = 0; i < 6; i++) begin
      wr(VECS[i][63:32]);
      chk(reg_rdata, VECS[i][31:0], "R10", "field readback");
      chk({31'b0, dp_reset}, 32'd0, "R9", "single arm write no reset");
    end
    wr(32'h0);

    // R1 R4 R8 R11: limit 2, enable, run, park 0
    dp_owned = 1'b1;
    wr(32'h0000_02A0);
    wait_start(seen); chk({31'b0, seen}, 32'd1, "R1", "first start");
    finish_desc(1'b0, 1'b1, 1'b1, "R1", ipre);
    chk({31'b0, irq}, 32'd0, "R4", "no irq after first");
    wait_start(seen); chk({31'b0, seen}, 32'd1, "R1", "second start automatic");
    finish_desc(1'b0, 1'b1, 1'b0, "R1", ipre);
    chk({31'b0, ipre}, 32'd0, "R8", "irq low before ack");
    chk({31'b0, irq}, 32'd1, "R4", "irq after limit");
    @(negedge clk); @(negedge clk);
    chk(reg_rdata, 32'h0000_0280, "R11", "run dropped on unowned");
    no_start(5, "R11");

    // R7 clear, then counter restarts
    wr(32'h8000_0280);
    chk({31'b0, irq}, 32'd0, "R7", "irq cleared");
    chk(reg_rdata, 32'h0000_0280, "R10", "bit31 reads zero");
    dp_owned = 1'b1;
    wr(32'h0000_02A0);
    wait_start(seen);
    finish_desc(1'b0, 1'b1, 1'b1, "R4", ipre);
    chk({31'b0, irq}, 32'd0, "R4", "counter restarted");
    wait_start(seen);
    finish_desc(1'b0, 1'b1, 1'b0, "R4", ipre);
    chk({31'b0, irq}, 32'd1, "R4", "irq after second round");
    wr(32'h8000_0000);
    chk({31'b0, irq}, 32'd0, "R7", "irq cleared again");

    // R2 R6 park and stop mid-descriptor
    dp_owned = 1'b1;
    wr(32'h0002_0020);
    wait_start(seen); chk({31'b0, seen}, 32'd1, "R2", "start with park");
    wr(32'h0002_0000);
    finish_desc(1'b0, 1'b0, 1'b1, "R2", ipre);
    no_start(10, "R2");
    chk(reg_rdata, 32'h0002_0000, "R2", "stopped fields");

    // R3 error ignored, then stop on error
    wr(32'h0000_0020);
    wait_start(seen);
    finish_desc(1'b1, 1'b1, 1'b1, "R3", ipre);
    wait_start(seen); chk({31'b0, seen}, 32'd1, "R3", "error ignored without stop flag");
    wr(32'h0000_0060);
    finish_desc(1'b1, 1'b1, 1'b1, "R3", ipre);
    no_start(10, "R3");
    chk(reg_rdata, 32'h0000_0040, "R3", "run dropped after error");

    // R5 zero limit
    wr(32'h0000_00A0);
    for (int k = 0; k < 3; k++) begin
      wait_start(seen);
      finish_desc(1'b0, 1'b1, (k != 2), "R5", ipre);
      chk({31'b0, irq}, 32'd0, "R5", "zero limit no irq");
    end
    @(negedge clk);

    // R9 software reset
    dp_owned = 1'b1;
    wr(32'h0000_01A0);
    wait_start(seen);
    finish_desc(1'b0, 1'b1, 1'b0, "R9", ipre);
    chk({31'b0, irq}, 32'd1, "R9", "irq pending before reset");
    @(negedge clk);
    wr(32'h0001_0080);
    chk({31'b0, dp_reset}, 32'd0, "R9", "first arm");
    wr(32'h0000_0080);
    chk({31'b0, dp_reset}, 32'd0, "R9", "disarm write");
    wr(32'h0001_0180);
    chk({31'b0, dp_reset}, 32'd0, "R9", "rearm only");
    chk(reg_rdata, 32'h0000_0180, "R9", "fields before reset");
    wr(32'h0001_0180);
    chk({31'b0, dp_reset}, 32'd1, "R9", "reset fires");
    chk(reg_rdata, 32'h0, "R9", "fields cleared");
    chk({31'b0, irq}, 32'd0, "R9", "irq cleared");
    n = 0;
    while (dp_reset && n < 50) begin
      reg_wr = (n == 0); reg_wdata = 32'h0000_00A0;
      n++;
      @(negedge clk);
    end
    reg_wr = 1'b0; reg_wdata = '0;
    chk(n, SRST_CYCLES, "R9", "reset length");
    chk(reg_rdata, 32'h0, "R9", "write during reset ignored");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule